// File: doc/BRIEF.md
# Transmit Descriptor Poll Scheduler

This block decides when an idle serial transmit channel looks at the ready flag of its next transmit buffer descriptor. While the channel is not sending a frame, an interval timer counts transmit bit-clock enables. Each time the programmed number of bit clocks has elapsed, the block issues a poll strobe and samples the descriptor-ready input in that same cycle. When the sampled flag is set, the block launches a frame. Otherwise it restarts the interval and keeps polling.

Software can cut the wait short by setting a demand bit through a small write port. This is meant for the case where the descriptor has just been marked ready. A pending demand forces a poll in the next cycle the channel is idle. That poll is flagged as high priority, so that neighbouring logic can yield the receive path for a moment. The demand bit clears itself once it has been served, and a demand raised during a frame waits until the transmitter goes idle.

After a frame is launched, polling stops. It resumes only after the busy input has been seen high and has then dropped again.

Top module: `txd_poll_sched`

## Requirements
- R1: After reset, poll_stb, start_frame, hi_prio and dmd_rd are all 0.
- R2: While idle, with no demand and the ready flag clear, poll_stb pulses for one cycle once every P bit-clock enables, where P is the effective period.
- R3: The effective period is poll_period clamped to the range 8 to 32. A value below 8 acts as 8, and a value above 32 acts as 32.
- R4: The interval advances only in cycles where bit_tick is 1.
- R5: No poll_stb is issued while tx_busy is 1. When tx_busy drops, the interval restarts from zero, and with bit_tick held at 1 the first poll follows P+1 cycles after the drop.
- R6: Writing 1 through the demand port (dmd_wr_en=1, dmd_wr_data=1) makes dmd_rd read 1 one cycle later. A poll with hi_prio=1 follows one cycle after that. hi_prio is 1 only on polls that serve a demand.
- R7: The demand bit clears when its poll is issued, so dmd_rd reads 0 together with that poll. A write with dmd_wr_data=0 has no effect.
- R8: A demand set while tx_busy is 1 is held, and no poll is issued during that time. The demand is served by a high-priority poll two cycles after tx_busy drops.
- R9: A poll that samples desc_ready=1 raises start_frame for exactly one cycle, together with poll_stb. After that, no poll is issued until tx_busy has risen and fallen again.
- R10: A demand poll that samples desc_ready=0 returns the block to periodic polling, and the next poll follows P bit clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Transmit bit-clock enable |
| tx_busy | input | 1 | Transmitter is sending a frame |
| desc_ready | input | 1 | Ready flag of the next transmit descriptor, sampled on polls |
| dmd_wr_en | input | 1 | Demand register write strobe |
| dmd_wr_data | input | 1 | Demand write value; only 1 sets |
| poll_period | input | 6 | Configured poll interval in bit clocks |
| dmd_rd | output | 1 | Current demand bit, as read by software |
| poll_stb | output | 1 | One-cycle descriptor poll strobe |
| start_frame | output | 1 | One-cycle frame launch pulse |
| hi_prio | output | 1 | Current poll is a demand poll |

## Verification
The bench builds the block with its default parameters: a 6-bit period input and a legal range of 8 to 32. With these values, a period input of 3 and one of 40 both fall outside the legal range, so the bench can check both clamp edges. With bit_tick held high, each interval equals the effective period in cycles, so the bench can count gaps, the restart after a busy drop, and the two-cycle demand latency exactly. A bit_tick divided by three then shows that only bit-clock enables advance the interval.

// File: rtl/txd_poll_pkg.sv
package txd_poll_pkg;

  // Channel phase seen by the poll scheduler
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // channel free, polling active
    PH_HOLD = 2'd1,  // frame launched, waiting for busy to rise
    PH_BUSY = 2'd2   // transmitter busy, polling frozen
  } txd_phase_e;

endpackage

// File: rtl/txd_interval_timer.sv
module txd_interval_timer #(
  parameter int PER_W = 6,
  parameter int MIN_P = 8,
  parameter int MAX_P = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             restart,
  input  logic [PER_W-1:0] period_cfg,
  output logic             expire
);

  localparam int CNT_W = $clog2(MAX_P + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] eff_per;
  logic             at_end;

  // Effective period: fixed when the range collapses, else clamped
  generate
    if (MIN_P == MAX_P) begin : g_fixed
      assign eff_per = CNT_W'(MAX_P);
    end else begin : g_clamp
      always_comb begin
        if (32'(period_cfg) < MIN_P)      eff_per = CNT_W'(MIN_P);
        else if (32'(period_cfg) > MAX_P) eff_per = CNT_W'(MAX_P);
        else                              eff_per = CNT_W'(period_cfg);
      end
    end
  endgenerate

  assign at_end = (cnt_q == eff_per - CNT_W'(1));
  assign expire = run & tick & at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/txd_demand_reg.sv
module txd_demand_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_data,
  input  logic serviced,
  output logic pending
);

  logic dmd_q, dmd_d;

  // A new set wins over a clear in the same cycle
  always_comb begin
    dmd_d = dmd_q;
    if (wr_en && wr_data) dmd_d = 1'b1;
    else if (serviced)    dmd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dmd_q <= 1'b0;
    else        dmd_q <= dmd_d;
  end

  assign pending = dmd_q;

endmodule

// File: rtl/txd_poll_ctrl.sv
module txd_poll_ctrl
  import txd_poll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_busy,
  input  logic desc_ready,
  input  logic expire,
  input  logic dmd_pending,
  output logic run,
  output logic restart,
  output logic dmd_take,
  output logic poll_stb,
  output logic start_frame,
  output logic hi_prio
);

  txd_phase_e ph_q, ph_d;
  logic       poll_fire;
  logic       stb_q, start_q, prio_q;

  assign run       = (ph_q == PH_IDLE) & ~tx_busy;
  assign poll_fire = run & (dmd_pending | expire);
  assign dmd_take  = poll_fire & dmd_pending;
  assign restart   = poll_fire | ~run;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (tx_busy)                      ph_d = PH_BUSY;
               else if (poll_fire && desc_ready) ph_d = PH_HOLD;
      PH_HOLD: if (tx_busy)                      ph_d = PH_BUSY;
      PH_BUSY: if (!tx_busy)                     ph_d = PH_IDLE;
      default:                                   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      stb_q   <= 1'b0;
      start_q <= 1'b0;
      prio_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      stb_q   <= poll_fire;
      start_q <= poll_fire & desc_ready;
      prio_q  <= dmd_take;
    end
  end

  assign poll_stb    = stb_q;
  assign start_frame = start_q;
  assign hi_prio     = prio_q;

endmodule

// File: rtl/txd_poll_sched.sv
module txd_poll_sched #(
  parameter int PER_W = 6,
  parameter int MIN_P = 8,
  parameter int MAX_P = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             tx_busy,
  input  logic             desc_ready,
  input  logic             dmd_wr_en,
  input  logic             dmd_wr_data,
  input  logic [PER_W-1:0] poll_period,
  output logic             dmd_rd,
  output logic             poll_stb,
  output logic             start_frame,
  output logic             hi_prio
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       run, restart, expire, dmd_take, dmd_pending;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  txd_interval_timer #(.PER_W(PER_W), .MIN_P(MIN_P), .MAX_P(MAX_P)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .run        (run),
    .tick       (bit_tick),
    .restart    (restart),
    .period_cfg (poll_period),
    .expire     (expire)
  );

  txd_demand_reg u_dmd (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (dmd_wr_en),
    .wr_data  (dmd_wr_data),
    .serviced (dmd_take),
    .pending  (dmd_pending)
  );

  txd_poll_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .tx_busy     (tx_busy),
    .desc_ready  (desc_ready),
    .expire      (expire),
    .dmd_pending (dmd_pending),
    .run         (run),
    .restart     (restart),
    .dmd_take    (dmd_take),
    .poll_stb    (poll_stb),
    .start_frame (start_frame),
    .hi_prio     (hi_prio)
  );

  assign dmd_rd = dmd_pending;

endmodule

// File: rtl/txd_poll_sched_chk.sv
module txd_poll_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_busy,
  input logic dmd_wr_en,
  input logic dmd_wr_data,
  input logic dmd_rd,
  input logic poll_stb,
  input logic start_frame,
  input logic hi_prio
);

  // R6: priority flag only accompanies a poll
  a_r6_prio_on_poll: assert property (@(posedge clk) disable iff (!rst_n)
    hi_prio |-> poll_stb);

  // R9: a launch only happens on a poll
  a_r9_start_on_poll: assert property (@(posedge clk) disable iff (!rst_n)
    start_frame |-> poll_stb);

  // R9: launch pulse lasts a single cycle
  a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_frame |=> !start_frame);

  // R5: polls come only from cycles where the transmitter was free
  a_r5_no_poll_busy: assert property (@(posedge clk) disable iff (!rst_n)
    poll_stb |-> !$past(tx_busy));

  // R7: a served demand reads back as zero unless rewritten meanwhile
  a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_prio && !$past(dmd_wr_en && dmd_wr_data)) |-> !dmd_rd);

  // R8: demand stays pending while the transmitter is busy
  a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (dmd_rd && tx_busy) |=> dmd_rd);

endmodule

bind txd_poll_sched txd_poll_sched_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_busy     (tx_busy),
  .dmd_wr_en   (dmd_wr_en),
  .dmd_wr_data (dmd_wr_data),
  .dmd_rd      (dmd_rd),
  .poll_stb    (poll_stb),
  .start_frame (start_frame),
  .hi_prio     (hi_prio)
);

// File: tb/txd_poll_sched_test.sv
module txd_poll_sched_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       tx_busy = 1'b0;
  logic       desc_ready = 1'b0;
  logic       dmd_wr_en = 1'b0;
  logic       dmd_wr_data = 1'b0;
  logic [5:0] poll_period = 6'd10;
  logic       dmd_rd, poll_stb, start_frame, hi_prio;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int ph = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  always @(negedge clk) begin
    if (ph >= tick_div - 1) ph <= 0;
    else                    ph <= ph + 1;
    bit_tick <= (ph == 0);
  end

  txd_poll_sched uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_busy(tx_busy),
    .desc_ready(desc_ready), .dmd_wr_en(dmd_wr_en), .dmd_wr_data(dmd_wr_data),
    .poll_period(poll_period), .dmd_rd(dmd_rd), .poll_stb(poll_stb),
    .start_frame(start_frame), .hi_prio(hi_prio)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int per);
    rst_n = 1'b0; tx_busy = 1'b0; desc_ready = 1'b0;
    dmd_wr_en = 1'b0; dmd_wr_data = 1'b0; tick_div = 1;
    poll_period = 6'(per);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_poll(input int maxc, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!poll_stb && n < maxc);
  endtask

  task automatic count_polls(input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (poll_stb) n++; end
  endtask

  task automatic write_dmd(input logic v);
    dmd_wr_en = 1'b1; dmd_wr_data = v;
    @(negedge clk);
    dmd_wr_en = 1'b0; dmd_wr_data = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 poll_stb", poll_stb, 0);
    chk("R1 start_frame", start_frame, 0);
    chk("R1 hi_prio", hi_prio, 0);
    chk("R1 dmd_rd", dmd_rd, 0);
  endtask

  task automatic t_periodic;
    int n;
    do_reset(10);
    wait_poll(200, n);
    wait_poll(200, n);
    chk("R2 gap period 10", n, 10);
    chk("R2 periodic hi_prio", hi_prio, 0);
    wait_poll(200, n);
    chk("R2 second gap", n, 10);
  endtask

  task automatic t_clamp;
    int n;
    do_reset(3);
    wait_poll(200, n); wait_poll(200, n);
    chk("R3 clamp low", n, 8);
    do_reset(40);
    wait_poll(200, n); wait_poll(200, n);
    chk("R3 clamp high", n, 32);
    do_reset(32);
    wait_poll(200, n); wait_poll(200, n);
    chk("R3 top of range", n, 32);
  endtask

  task automatic t_tick;
    int n;
    do_reset(8);
    tick_div = 3;
    wait_poll(300, n); wait_poll(300, n);
    chk("R4 gap with divided tick", n, 24);
  endtask

  task automatic t_busy;
    int n;
    do_reset(12);
    wait_poll(200, n);
    tx_busy = 1'b1;
    count_polls(100, n);
    chk("R5 no polls while busy", n, 0);
    tx_busy = 1'b0;
    wait_poll(200, n);
    chk("R5 restart after busy drop", n, 13);
  endtask

  task automatic t_demand;
    int n;
    do_reset(32);
    wait_poll(200, n);
    repeat (5) @(negedge clk);
    write_dmd(1'b0);
    chk("R7 zero write ignored", dmd_rd, 0);
    count_polls(4, n);
    chk("R7 zero write no poll", n, 0);
    write_dmd(1'b1);
    chk("R6 demand readable", dmd_rd, 1);
    chk("R6 not yet polled", poll_stb, 0);
    @(negedge clk);
    chk("R6 demand poll", poll_stb, 1);
    chk("R6 demand priority", hi_prio, 1);
    chk("R7 self clear", dmd_rd, 0);
    chk("R10 no start when not ready", start_frame, 0);
    wait_poll(200, n);
    chk("R10 periodic resumes", n, 32);
    chk("R10 periodic poll low priority", hi_prio, 0);
  endtask

  task automatic t_held;
    int n;
    do_reset(32);
    tx_busy = 1'b1;
    repeat (3) @(negedge clk);
    write_dmd(1'b1);
    count_polls(20, n);
    chk("R8 no poll while held", n, 0);
    chk("R8 demand held", dmd_rd, 1);
    tx_busy = 1'b0;
    @(negedge clk);
    chk("R8 not yet", poll_stb, 0);
    @(negedge clk);
    chk("R8 served after idle", poll_stb, 1);
    chk("R8 served high priority", hi_prio, 1);
  endtask

  task automatic t_start;
    int n;
    do_reset(8);
    desc_ready = 1'b1;
    repeat (2) @(negedge clk);
    write_dmd(1'b1);
    @(negedge clk);
    chk("R9 start on demand poll", start_frame, 1);
    chk("R9 poll with start", poll_stb, 1);
    @(negedge clk);
    chk("R9 start one cycle", start_frame, 0);
    count_polls(60, n);
    chk("R9 no polls after launch", n, 0);
    tx_busy = 1'b1;
    count_polls(20, n);
    chk("R9 no polls during frame", n, 0);
    desc_ready = 1'b0;
    tx_busy = 1'b0;
    wait_poll(200, n);
    chk("R9 polling resumes after frame", n, 9);
    desc_ready = 1'b1;
    wait_poll(200, n);
    chk("R9 periodic launch", start_frame, 1);
    chk("R9 periodic launch low priority", hi_prio, 0);
  endtask

  initial begin
    t_reset();
    t_periodic();
    t_clamp();
    t_tick();
    t_busy();
    t_demand();
    t_held();
    t_start();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule